// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a down-counting tick timer for a processor subsystem. Software sets a reload value, then enables the timer. The counter then steps down once per counting tick. A counting tick is either every core clock or every strobe on a slower reference tick input, and a control bit picks between the two. When the count has stepped through zero, the block sets a sticky expiry flag and reloads. If interrupts are enabled, it also raises a one-cycle pending request for the interrupt controller.

The block is reached through a plain word-wide register port with four words: control/status, reload value, current value and a constant calibration word. Reads have side effects. A read of the control word clears the expiry flag, and a write of any value to the current-value word restarts the period. A zero reload value makes the timer one-shot: it stops itself after the next expiry.

Top module: `systick_timer`

## Requirements
- R1: After reset the control, reload and current-value words read 0 and `irq_pend_o` is low.
- R2: Control word layout is: bit 0 run enable, bit 1 interrupt enable, bit 2 source select (1 = core clock, 0 = `ref_tick_i`), bit 16 expiry flag, all other bits 0. A write changes only bits 2:0, and bit 16 of the write data is ignored.
- R3: Reload and current value are 24 bits wide. Bits 31:24 read as 0 and ignore writes.
- R4: When run enable goes 0 to 1, the counter takes the reload value. While enabled it then decreases by one per counting tick: each core clock with source select 1, each cycle with `ref_tick_i` high with source select 0.
- R5: A counting tick that finds the counter at 0 is an expiry. It puts the reload value back into the counter and sets the expiry flag, so one period is reload+1 counting ticks.
- R6: On expiry with interrupt enable 1, `irq_pend_o` is high for exactly the one cycle after the expiring edge. With interrupt enable 0 it stays low.
- R7: A control-word read returns the flag as it stood, then clears it. An expiry in the same cycle as the read leaves the flag set.
- R8: A write of any value to the current-value word (word offset 2) loads the counter from the reload value and clears the expiry flag.
- R9: An expiry while the reload value is 0 clears run enable, and counting stops.
- R10: Changing source select while enabled and staying enabled reloads the counter.
- R11: While disabled, the current-value word reads 0, and the counter neither counts nor reloads on ticks.
- R12: The calibration word (word offset 3) always reads the parameter `CALIB_VAL`, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One-cycle reference tick strobe |
| addr_i | input | 2 | Word offset: 0 control, 1 reload, 2 current, 3 calibration |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (read side effects apply at the clock edge) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when `rd_en_i` is low |
| irq_pend_o | output | 1 | One-cycle pending request on expiry |

## Verification
Read data is combinational on the current state. It shows the effect of a write or a counting tick in the cycle after the edge that applied it. The flag clear from a read appears only after that read's own edge. The pending pulse is registered and appears one cycle after the expiring edge. The bench drives inputs just after the falling edge and samples just before the next rising edge, so every read shows the state after the previous edge. It compares read data and the pending output against its model on every clock. The directed checks count edges explicitly, and the pending pulse is checked after the expiring edge.

// File: rtl/systick_pkg.sv
package systick_pkg;
  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_CALIB   = 2'd3
  } reg_sel_e;

  localparam int BIT_EN      = 0;
  localparam int BIT_TICKINT = 1;
  localparam int BIT_SRC     = 2;
  localparam int BIT_FLAG    = 16;
endpackage

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int                CNT_W     = 24,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] CALIB_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  reg_sel_e          sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic              tickint_o,
  output logic              src_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             en_q, tickint_q, src_q, flag_q;
  logic [CNT_W-1:0] reload_q;
  logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
  logic             en_d;
  logic [DATA_W-1:0] ctrl_word, mux_word;
  wire              unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign wr_ctrl   = wr_en_i && (sel_i == REG_CTRL);
  assign wr_reload = wr_en_i && (sel_i == REG_RELOAD);
  assign wr_cur    = wr_en_i && (sel_i == REG_CURRENT);
  assign rd_ctrl   = rd_en_i && (sel_i == REG_CTRL);

  // restart: current-value write, enable rise, or source swap while running
  assign load_o = wr_cur
               || (wr_ctrl && wdata_i[BIT_EN] && !en_q)
               || (wr_ctrl && wdata_i[BIT_EN] && en_q && (wdata_i[BIT_SRC] != src_q));

  always_comb begin
    en_d = en_q;
    if (wr_ctrl)                           en_d = wdata_i[BIT_EN];
    else if (expire_i && reload_q == '0)   en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      tickint_q <= 1'b0;
      src_q     <= 1'b0;
      flag_q    <= 1'b0;
      reload_q  <= '0;
    end else begin
      en_q <= en_d;
      if (wr_ctrl) begin
        tickint_q <= wdata_i[BIT_TICKINT];
        src_q     <= wdata_i[BIT_SRC];
      end
      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
      if (expire_i)                flag_q <= 1'b1;
      else if (rd_ctrl || wr_cur)  flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[BIT_EN]      = en_q;
    ctrl_word[BIT_TICKINT] = tickint_q;
    ctrl_word[BIT_SRC]     = src_q;
    ctrl_word[BIT_FLAG]    = flag_q;
    unique case (sel_i)
      REG_CTRL:    mux_word = ctrl_word;
      REG_RELOAD:  mux_word = {{PAD_W{1'b0}}, reload_q};
      REG_CURRENT: mux_word = en_q ? {{PAD_W{1'b0}}, cnt_i} : '0;
      default:     mux_word = CALIB_VAL;
    endcase
  end

  assign rdata_o   = rd_en_i ? mux_word : '0;
  assign en_o      = en_q;
  assign tickint_o = tickint_q;
  assign src_o     = src_q;
  assign flag_o    = flag_q;
  assign reload_o  = reload_q;
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_core_i,
  input  logic             ref_tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o   = en_i && (src_core_i || ref_tick_i);
  assign expire_o = step_o && (cnt_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i || expire_o) cnt_q <= reload_i;
    else if (step_o)             cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CALIB_VAL = 32'h0000_2710
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_pend_o
);
  logic             en, tickint, src, flag, load, step, expire;
  logic [CNT_W-1:0] reload, cnt;
  logic             pend_q;

  systick_regs #(
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .CALIB_VAL(DATA_W'(CALIB_VAL))
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (reg_sel_e'(addr_i)),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .expire_i (expire),
    .cnt_i    (cnt),
    .en_o     (en),
    .tickint_o(tickint),
    .src_o    (src),
    .flag_o   (flag),
    .reload_o (reload),
    .load_o   (load),
    .rdata_o  (rdata_o)
  );

  systick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .src_core_i(src),
    .ref_tick_i(ref_tick_i),
    .load_i    (load),
    .reload_i  (reload),
    .cnt_o     (cnt),
    .step_o    (step),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= expire && tickint;
  end

  assign irq_pend_o = pend_q;
endmodule

// File: rtl/systick_sva.sv
module systick_sva #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_pend_o,
  input logic              en,
  input logic              flag,
  input logic              load,
  input logic              step,
  input logic              expire,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  cnt
);
  AST_PEND_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o |=> !irq_pend_o);                                          // R6
  AST_PEND_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o |-> flag);                                                 // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (cnt == $past(reload)));                                   // R5
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));         // R4
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !load) |=> $stable(cnt));                                     // R11
  AST_ZERO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload == '0 && !(wr_en_i && addr_i == 2'd0)) |=> !en);    // R9
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == 2'd1 || addr_i == 2'd2)) |-> (rdata_o[DATA_W-1:CNT_W] == '0)); // R3
endmodule

bind systick_timer systick_sva #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .irq_pend_o(irq_pend_o),
  .en        (en),
  .flag      (flag),
  .load      (load),
  .step      (step),
  .expire    (expire),
  .reload    (reload),
  .cnt       (cnt)
);

// File: tb/test_systick_timer.sv
`timescale 1ns/1ps
module test_systick_timer;
  localparam logic [31:0] CALIB = 32'h0000_2710;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_pend;

  always #2.5 clk = ~clk;

  systick_timer i_systick_timer (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_pend_o(irq_pend)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_en, m_ti, m_src, m_flag, m_pend;
  logic [23:0] m_rel, m_cnt;

  always @(posedge clk or negedge rst_n) begin : model
    bit stp, ld, ex, wc;
    if (!rst_n) begin
      m_en = 0; m_ti = 0; m_src = 0; m_flag = 0; m_pend = 0;
      m_rel = '0; m_cnt = '0;
    end else begin
      wc  = wr_en && addr == 2'd0;
      stp = m_en && (m_src || ref_tick);
      ld  = (wr_en && addr == 2'd2) || (wc && wdata[0] && (!m_en || wdata[2] != m_src));
      ex  = stp && m_cnt == 0 && !ld;
      m_pend = ex && m_ti;
      if (ex) m_flag = 1;
      else if ((rd_en && addr == 2'd0) || (wr_en && addr == 2'd2)) m_flag = 0;
      if (ld || ex) m_cnt = m_rel;
      else if (stp) m_cnt = m_cnt - 24'd1;
      if (wc) begin
        m_en = wdata[0]; m_ti = wdata[1]; m_src = wdata[2];
      end else if (ex && m_rel == 0) m_en = 0;
      if (wr_en && addr == 2'd1) m_rel = wdata[23:0];
    end
  end

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0:    return {15'd0, m_flag, 13'd0, m_src, m_ti, m_en};
      2'd1:    return {8'd0, m_rel};
      2'd2:    return m_en ? {8'd0, m_cnt} : 32'd0;
      default: return CALIB;
    endcase
  endfunction

  function automatic string rtag(logic [1:0] a);
    case (a)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R12";
    endcase
  endfunction

  // per-clock comparison just before the rising edge
  always @(negedge clk) begin
    #1.8;
    if (rst_n && !done) begin
      chk("R6 pend", {31'd0, irq_pend}, {31'd0, m_pend});
      if (rd_en) chk(rtag(addr), rdata, m_read(addr));
    end
  end

  // one op per cycle: drive after falling edge, sample before rising edge
  task automatic op(bit w, bit r, logic [1:0] a, logic [31:0] d, bit t,
                    output logic [31:0] smp);
    wr_en = w; rd_en = r; addr = a; wdata = d; ref_tick = t;
    #1.5;
    smp = rdata;
    @(negedge clk);
    #0.5;
    wr_en = 0; rd_en = 0; ref_tick = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    logic [31:0] s;
    op(1, 0, a, d, 0, s);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    logic [31:0] s;
    op(0, 1, a, 0, 0, s);
    chk(tag, s, exp);
  endtask

  task automatic tick(bit exp_pend, string tag);
    ref_tick = 1;
    #1.5;
    @(negedge clk);
    chk(tag, {31'd0, irq_pend}, {31'd0, exp_pend});
    #0.5;
    ref_tick = 0;
  endtask

  task automatic idle(int n);
    logic [31:0] s;
    for (int i = 0; i < n; i++) op(0, 0, 2'd0, 0, 0, s);
  endtask

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    chk("R1 pend", {31'd0, irq_pend}, 32'd0);
    rst_n = 1;
    #0.5;
    rd(2'd0, 32'd0, "R1 ctrl");
    rd(2'd2, 32'd0, "R1 current");
    rd(2'd1, 32'd0, "R1 reload");

    wr(2'd1, 32'hAB00_0003);
    rd(2'd1, 32'd3, "R3 reload upper bits");
    wr(2'd0, 32'hFFFF_FFFB);
    rd(2'd0, 32'd3, "R2 ctrl write mask");
    rd(2'd2, 32'd3, "R4 load on enable");
    tick(0, "R4"); tick(0, "R4"); tick(0, "R4");
    rd(2'd2, 32'd0, "R4 count down");
    tick(1, "R6 pend on expiry");
    rd(2'd2, 32'd3, "R5 wrap to reload");
    rd(2'd0, 32'h0001_0003, "R7 flag read");
    rd(2'd0, 32'd3, "R7 flag cleared");

    wr(2'd0, 32'd1);
    tick(0, "R6"); tick(0, "R6"); tick(0, "R6");
    tick(0, "R6 no pend with tickint off");
    rd(2'd0, 32'h0001_0001, "R5 flag set");
    tick(0, "R6"); tick(0, "R6"); tick(0, "R6"); tick(0, "R6");
    tick(0, "R4");
    wr(2'd2, 32'h0000_0123);
    rd(2'd2, 32'd3, "R8 current write reload");
    rd(2'd0, 32'd1, "R8 flag cleared");

    tick(0, "R4");
    wr(2'd0, 32'd5);
    rd(2'd2, 32'd3, "R10 reload on source change");
    wr(2'd0, 32'd1);
    rd(2'd2, 32'd3, "R10 reload on source change back");

    wr(2'd0, 32'd0);
    rd(2'd2, 32'd0, "R11 disabled reads zero");
    tick(0, "R11"); tick(0, "R11");
    rd(2'd2, 32'd0, "R11 still zero");
    wr(2'd0, 32'd1);
    rd(2'd2, 32'd3, "R4 reload on re-enable");

    wr(2'd1, 32'd0);
    wr(2'd2, 32'd7);
    tick(0, "R9");
    rd(2'd0, 32'h0001_0000, "R9 enable cleared");
    tick(0, "R9");
    rd(2'd2, 32'd0, "R9 stopped");

    rd(2'd3, CALIB, "R12 calib");
    wr(2'd3, 32'd0);
    rd(2'd3, CALIB, "R12 calib after write");

    wr(2'd1, 32'd1);
    wr(2'd0, 32'd1);
    tick(0, "R4");
    op(0, 1, 2'd0, 0, 1, s);
    chk("R7 read before expiry", s, 32'd1);
    rd(2'd0, 32'h0001_0001, "R7 expiry beats clear");

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h00FF_FFFF, "R3 reload 24 bits");

    wr(2'd1, 32'd2);
    wr(2'd0, 32'd7);
    for (int i = 0; i < 12; i++) rd(2'd2, m_read(2'd2), "R4 core clock run");
    idle(20);
    wr(2'd2, 32'h55);
    for (int i = 0; i < 6; i++) rd(2'd0, m_read(2'd0), "R8 run");
    wr(2'd0, 32'd3);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] q;
      op(0, 1, 2'd2, 0, bit'(i % 2), q);
    end
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule